// File: doc/BRIEF.md
# Handshaked Serial Command Protocol Engine

This block is the framing layer of a power-manager controller. A host exchanges single bytes with it through a shift-register byte and a direction flag. It paces every byte with two active-low handshake lines that sit in a shared 8-bit port-B value. A transaction starts with a command byte. If the command's argument length is variable, a length byte follows, and then come the argument bytes. When all arguments are in, the engine pulses a dispatch strobe towards a separate command executor and waits for it to finish. It then returns an optional response-length byte and the response bytes.

A per-command length table is given as parameters and holds the argument length and response length for each code. The value 0xFF stands for "variable, carried on the wire". Codes that are in the table but marked as not executed are answered by the engine itself with zeros. The same applies to codes that are not in the table at all. The executor reads arguments and writes responses through two small byte buffers.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset the port-B value reads 0x18 (both handshake bits inactive), `sr_done`, `cmd_go` and `sr_out` are zero, and the engine is idle.
- R2: The engine reacts only when port B differs from the value it last recorded. Port-B bit 3 is the device acknowledge and bit 4 is the host request, both active low. Both bits low is invalid and causes no transfer and no change to port B.
- R3: When the host drives request high while acknowledge is low (port B 0x10), the engine sets acknowledge high (port B becomes 0x18) one cycle later.
- R4: A request (request low, acknowledge high, port B 0x08) makes the engine drive acknowledge low (port B 0x00). When the byte is accepted, `sr_done` pulses for one cycle two clock edges after the port-B write.
- R5: While idle or receiving arguments, a byte is accepted only with `sr_dir`=1 (host to device). While responding, a byte is accepted only with `sr_dir`=0. Otherwise the byte is skipped: no `sr_done`, no state change, but acknowledge is still driven low.
- R6: The byte taken in the idle state is the command code. Its lengths come from the table: 0x78 has 0 arguments and a variable response; 0x10 has 1 argument and a 0-byte response; 0x20 has variable arguments and a variable response; 0x38 has 0 arguments and a 4-byte response. These four codes are executed. 0x40 has 2 arguments and a 3-byte response, and 0x41 is variable/variable; neither is executed. All other codes have 0 arguments and a 1-byte response and are not executed. A command with 0 arguments dispatches on its code byte.
- R7: With a variable argument length, the first byte after the code is the argument count.
- R8: The argument buffer holds 32 bytes. Later bytes are counted towards completion but not stored, and reading an index of 32 or more returns 0.
- R9: When the count of received arguments reaches the expected length, an executed command pulses `cmd_go` in the same cycle as the final `sr_done`, with `cmd_code` and `cmd_arg_cnt` valid. The engine then accepts no byte until `exec_done`, and a request made meanwhile is served afterwards.
- R10: A fixed response length N sends N bytes. Byte i is response-buffer entry i if i is below both the executor's size and 32, and 0 otherwise. After that the engine is idle, and it is idle at once if N is 0.
- R11: With a variable response length, the first byte sent is the response size, and that many bytes follow.
- R12: A command that is not executed gets no `cmd_go` and responds with zeros of its table length. If that length is variable, the response is a single length byte of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pb_we | input | 1 | Host write strobe for port B |
| pb_wdata | input | 8 | Port-B value written by the host |
| pb_rdata | output | 8 | Current port-B value, including the engine's acknowledge bit |
| sr_dir | input | 1 | Shift direction: 1 host to device, 0 device to host |
| sr_in | input | 8 | Byte shifted in from the host |
| sr_out | output | 8 | Byte presented to the host |
| sr_done | output | 1 | One-cycle byte-complete pulse |
| cmd_go | output | 1 | One-cycle dispatch strobe |
| cmd_code | output | 8 | Command code being executed |
| cmd_arg_cnt | output | 8 | Number of arguments received |
| arg_rd_idx | input | 8 | Argument buffer read index |
| arg_rd_data | output | 8 | Argument buffer read data |
| rsp_we | input | 1 | Response buffer write enable |
| rsp_wr_idx | input | 8 | Response buffer write index |
| rsp_wr_data | input | 8 | Response buffer write data |
| exec_done | input | 1 | Executor finished pulse |
| exec_rsp_len | input | 8 | Response size from the executor |

## Verification
The bench builds the engine with its default parameters: 32-byte buffers and the six-entry table above, with 0-argument, 1-byte-response defaults for every other code. With that table, a sweep over all 256 command codes covers every length combination. These are fixed and variable arguments, fixed, zero and variable responses, and executed and not-executed commands. A second sweep of variable argument counts from 0 to 34 crosses the 32-byte buffer edge, so both the dropped argument writes and the zero-filled response reads past the edge are exercised. Directed sequences cover direction errors in both phases, the invalid handshake state, and a request made while the executor is busy.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
   localparam int ACK_BIT = 3;
   localparam int REQ_BIT = 4;
   localparam logic [7:0] LEN_VAR = 8'hFF;
   localparam logic [7:0] PB_IDLE = 8'h18;

   typedef struct packed {
      logic       cvar;
      logic [7:0] clen;
      logic       rvar;
      logic [7:0] rlen;
      logic       exec;
   } lens_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_WAIT = 2'd2,
      ST_RSP  = 2'd3
   } st_e;
endpackage

// File: rtl/hs_len_lut.sv
`timescale 1ns/1ps
module hs_len_lut
   import hs_pkg::*;
#(
   parameter int             N        = 6,
   parameter logic [N*8-1:0] CODES    = '0,
   parameter logic [N*8-1:0] CLENS    = '0,
   parameter logic [N*8-1:0] RLENS    = '0,
   parameter logic [N-1:0]   EXEC     = '0,
   parameter logic [7:0]     UNK_CLEN = 8'h00,
   parameter logic [7:0]     UNK_RLEN = 8'h01
) (
   input  logic [7:0] code,
   output lens_t      lens
);
   if (N < 1 || N > 64) begin : g_bad_n
      $error("hs_len_lut: N out of range");
   end

   logic [N-1:0] hit;

   for (genvar i = 0; i < N; i++) begin : g_match
      assign hit[i] = (code == CODES[i*8 +: 8]);
   end

   always_comb begin
      lens.cvar = (UNK_CLEN == LEN_VAR);
      lens.clen = UNK_CLEN;
      lens.rvar = (UNK_RLEN == LEN_VAR);
      lens.rlen = UNK_RLEN;
      lens.exec = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit[i]) begin
            lens.cvar = (CLENS[i*8 +: 8] == LEN_VAR);
            lens.clen = CLENS[i*8 +: 8];
            lens.rvar = (RLENS[i*8 +: 8] == LEN_VAR);
            lens.rlen = RLENS[i*8 +: 8];
            lens.exec = EXEC[i];
         end
      end
   end
endmodule

// File: rtl/hs_byte_buf.sv
`timescale 1ns/1ps
module hs_byte_buf #(
   parameter int DEPTH = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] widx,
   input  logic [7:0] wdata,
   input  logic [7:0] ridx,
   output logic [7:0] rdata
);
   if (DEPTH < 2 || DEPTH > 128) begin : g_bad_depth
      $error("hs_byte_buf: DEPTH out of range");
   end

   logic [7:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[i] <= 8'h00;
         end else if (we && widx == 8'(i)) begin
            mem[i] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < DEPTH; i++) begin
         if (ridx == 8'(i)) rdata = mem[i];
      end
   end
endmodule

// File: rtl/hs_cmd_engine.sv
`timescale 1ns/1ps
module hs_cmd_engine
   import hs_pkg::*;
#(
   parameter int                 BUF_DEPTH = 32,
   parameter int                 TBL_N     = 6,
   parameter logic [TBL_N*8-1:0] TBL_CODE  = {8'h41, 8'h40, 8'h38, 8'h20, 8'h10, 8'h78},
   parameter logic [TBL_N*8-1:0] TBL_CLEN  = {8'hFF, 8'h02, 8'h00, 8'hFF, 8'h01, 8'h00},
   parameter logic [TBL_N*8-1:0] TBL_RLEN  = {8'hFF, 8'h03, 8'h04, 8'hFF, 8'h00, 8'hFF},
   parameter logic [TBL_N-1:0]   TBL_EXEC  = 6'b001111,
   parameter logic [7:0]         UNK_CLEN  = 8'h00,
   parameter logic [7:0]         UNK_RLEN  = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pb_we,
   input  logic [7:0] pb_wdata,
   output logic [7:0] pb_rdata,
   input  logic       sr_dir,
   input  logic [7:0] sr_in,
   output logic [7:0] sr_out,
   output logic       sr_done,
   output logic       cmd_go,
   output logic [7:0] cmd_code,
   output logic [7:0] cmd_arg_cnt,
   input  logic [7:0] arg_rd_idx,
   output logic [7:0] arg_rd_data,
   input  logic       rsp_we,
   input  logic [7:0] rsp_wr_idx,
   input  logic [7:0] rsp_wr_data,
   input  logic       exec_done,
   input  logic [7:0] exec_rsp_len
);
   st_e        state_q, state_d;
   logic [7:0] pb_q, pb_d, last_q, last_d;
   logic [7:0] cmd_q, cmd_d, clen_q, clen_d, rlen_q, rlen_d;
   logic [7:0] arg_cnt_q, arg_cnt_d, rsp_pos_q, rsp_pos_d;
   logic [7:0] rsp_sz_q, rsp_sz_d, sr_out_q, sr_out_d;
   logic       cvar_q, cvar_d, rvar_q, rvar_d, exec_q, exec_d;
   logic       done_q, done_d, go_q, go_d;
   logic       req_ok, arg_we;
   logic [1:0] hs;
   logic [7:0] rsp_rd, rsp_byte;
   lens_t      lk;

   hs_len_lut #(
      .N(TBL_N), .CODES(TBL_CODE), .CLENS(TBL_CLEN), .RLENS(TBL_RLEN),
      .EXEC(TBL_EXEC), .UNK_CLEN(UNK_CLEN), .UNK_RLEN(UNK_RLEN)
   ) u_lut (
      .code(sr_in),
      .lens(lk)
   );

   hs_byte_buf #(.DEPTH(BUF_DEPTH)) u_arg_buf (
      .clk(clk), .rst_n(rst_n),
      .we(arg_we), .widx(arg_cnt_q), .wdata(sr_in),
      .ridx(arg_rd_idx), .rdata(arg_rd_data)
   );

   hs_byte_buf #(.DEPTH(BUF_DEPTH)) u_rsp_buf (
      .clk(clk), .rst_n(rst_n),
      .we(rsp_we), .widx(rsp_wr_idx), .wdata(rsp_wr_data),
      .ridx(rsp_pos_q), .rdata(rsp_rd)
   );

   assign rsp_byte = (rsp_pos_q < rsp_sz_q) ? rsp_rd : 8'h00;
   assign hs       = {pb_q[REQ_BIT], pb_q[ACK_BIT]};

   always_comb begin
      state_d   = state_q;
      pb_d      = pb_q;
      last_d    = last_q;
      cmd_d     = cmd_q;
      clen_d    = clen_q;
      rlen_d    = rlen_q;
      cvar_d    = cvar_q;
      rvar_d    = rvar_q;
      exec_d    = exec_q;
      arg_cnt_d = arg_cnt_q;
      rsp_pos_d = rsp_pos_q;
      rsp_sz_d  = rsp_sz_q;
      sr_out_d  = sr_out_q;
      done_d    = 1'b0;
      go_d      = 1'b0;
      req_ok    = 1'b0;
      arg_we    = 1'b0;

      // executor completion
      if (state_q == ST_WAIT && exec_done) begin
         rsp_sz_d = exec_rsp_len;
         state_d  = ST_RSP;
      end

      // handshake decode on change
      if (pb_q != last_q) begin
         case (hs)
            2'b10: begin
               pb_d[ACK_BIT] = 1'b1;
               last_d        = pb_d;
            end
            2'b01: begin
               if (state_q != ST_WAIT) begin
                  pb_d[ACK_BIT] = 1'b0;
                  last_d        = pb_d;
                  req_ok        = 1'b1;
               end
            end
            default: last_d = pb_q;
         endcase
      end

      if (req_ok) begin
         case (state_q)
            ST_IDLE: if (sr_dir) begin
               cmd_d     = sr_in;
               cvar_d    = lk.cvar;
               clen_d    = lk.clen;
               rvar_d    = lk.rvar;
               rlen_d    = lk.rlen;
               exec_d    = lk.exec;
               arg_cnt_d = 8'h00;
               rsp_pos_d = 8'h00;
               state_d   = ST_CMD;
               done_d    = 1'b1;
            end
            ST_CMD: if (sr_dir) begin
               if (cvar_q) begin
                  clen_d = sr_in;
                  cvar_d = 1'b0;
               end else begin
                  arg_we    = 1'b1;
                  arg_cnt_d = arg_cnt_q + 8'd1;
               end
               done_d = 1'b1;
            end
            ST_RSP: if (!sr_dir) begin
               if (rvar_q) begin
                  sr_out_d = rsp_sz_q;
                  rlen_d   = rsp_sz_q;
                  rvar_d   = 1'b0;
               end else if (rsp_pos_q < rlen_q) begin
                  sr_out_d  = rsp_byte;
                  rsp_pos_d = rsp_pos_q + 8'd1;
               end
               done_d = 1'b1;
            end
            default: ;
         endcase
      end

      // argument reception complete
      if (state_d == ST_CMD && !cvar_d && clen_d == arg_cnt_d) begin
         if (exec_d) begin
            go_d    = 1'b1;
            state_d = ST_WAIT;
         end else begin
            rsp_sz_d = 8'h00;
            state_d  = ST_RSP;
         end
      end

      // response complete
      if (state_d == ST_RSP && !rvar_d && rlen_d == rsp_pos_d) begin
         state_d = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pb_q      <= PB_IDLE;
         last_q    <= PB_IDLE;
         cmd_q     <= 8'h00;
         clen_q    <= 8'h00;
         rlen_q    <= 8'h00;
         cvar_q    <= 1'b0;
         rvar_q    <= 1'b0;
         exec_q    <= 1'b0;
         arg_cnt_q <= 8'h00;
         rsp_pos_q <= 8'h00;
         rsp_sz_q  <= 8'h00;
         sr_out_q  <= 8'h00;
         done_q    <= 1'b0;
         go_q      <= 1'b0;
      end else begin
         state_q   <= state_d;
         pb_q      <= pb_we ? pb_wdata : pb_d;
         last_q    <= last_d;
         cmd_q     <= cmd_d;
         clen_q    <= clen_d;
         rlen_q    <= rlen_d;
         cvar_q    <= cvar_d;
         rvar_q    <= rvar_d;
         exec_q    <= exec_d;
         arg_cnt_q <= arg_cnt_d;
         rsp_pos_q <= rsp_pos_d;
         rsp_sz_q  <= rsp_sz_d;
         sr_out_q  <= sr_out_d;
         done_q    <= done_d;
         go_q      <= go_d;
      end
   end

   assign pb_rdata    = pb_q;
   assign sr_out      = sr_out_q;
   assign sr_done     = done_q;
   assign cmd_go      = go_q;
   assign cmd_code    = cmd_q;
   assign cmd_arg_cnt = arg_cnt_q;
endmodule

// File: rtl/hs_cmd_engine_chk.sv
`timescale 1ns/1ps
module hs_cmd_engine_chk
   import hs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] pb,
   input logic [7:0] last_b,
   input logic       pb_we,
   input logic       sr_dir,
   input logic       sr_done,
   input logic       cmd_go,
   input logic       exec_done,
   input st_e        state,
   input logic [7:0] rsp_pos,
   input logic [7:0] rlen,
   input logic       rlen_var
);
   AST_DONE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      sr_done |-> (!$past(pb[REQ_BIT]) && $past(pb[ACK_BIT]))); // R4

   AST_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_done && !$past(pb_we)) |-> !pb[ACK_BIT]); // R4

   AST_RELEASE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pb[REQ_BIT]) && !$past(pb[ACK_BIT]) && $past(pb != last_b) && !$past(pb_we))
      |-> pb[ACK_BIT]); // R3

   AST_DIR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_done && $past(state == ST_RSP)) |-> !$past(sr_dir)); // R5

   AST_DIR_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_done && $past(state != ST_RSP)) |-> $past(sr_dir)); // R5

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !exec_done) |=> (state == ST_WAIT && !sr_done)); // R9

   AST_GO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |-> sr_done); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RSP && !rlen_var) |-> (rsp_pos <= rlen)); // R10
endmodule

bind hs_cmd_engine hs_cmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pb(pb_q), .last_b(last_q), .pb_we(pb_we),
   .sr_dir(sr_dir), .sr_done(done_q), .cmd_go(go_q), .exec_done(exec_done),
   .state(state_q), .rsp_pos(rsp_pos_q), .rlen(rlen_q), .rlen_var(rvar_q)
);

// File: tb/hs_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module hs_cmd_engine_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pb_we = 1'b0;
   logic [7:0] pb_wdata = 8'h00;
   logic [7:0] pb_rdata;
   logic       sr_dir = 1'b1;
   logic [7:0] sr_in = 8'h00;
   logic [7:0] sr_out;
   logic       sr_done, cmd_go;
   logic [7:0] cmd_code, cmd_arg_cnt;
   logic [7:0] arg_rd_idx = 8'h00;
   logic [7:0] arg_rd_data;
   logic       rsp_we = 1'b0;
   logic [7:0] rsp_wr_idx = 8'h00, rsp_wr_data = 8'h00;
   logic       exec_done = 1'b0;
   logic [7:0] exec_rsp_len = 8'h00;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   hs_cmd_engine dut_i (
      .clk(clk), .rst_n(rst_n), .pb_we(pb_we), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
      .sr_dir(sr_dir), .sr_in(sr_in), .sr_out(sr_out), .sr_done(sr_done),
      .cmd_go(cmd_go), .cmd_code(cmd_code), .cmd_arg_cnt(cmd_arg_cnt),
      .arg_rd_idx(arg_rd_idx), .arg_rd_data(arg_rd_data),
      .rsp_we(rsp_we), .rsp_wr_idx(rsp_wr_idx), .rsp_wr_data(rsp_wr_data),
      .exec_done(exec_done), .exec_rsp_len(exec_rsp_len)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // bench model of the length table (R6)
   task automatic exp_lens(input logic [7:0] c, output bit cv, output int cl,
                           output bit rv, output int rl, output bit ex);
      cv = 0; cl = 0; rv = 0; rl = 1; ex = 0;
      case (c)
         8'h78: begin cl = 0; rv = 1; ex = 1; end
         8'h10: begin cl = 1; rl = 0; ex = 1; end
         8'h20: begin cv = 1; rv = 1; ex = 1; end
         8'h38: begin cl = 0; rl = 4; ex = 1; end
         8'h40: begin cl = 2; rl = 3; end
         8'h41: begin cv = 1; rv = 1; end
         default: ;
      endcase
   endtask

   function automatic int esize(input logic [7:0] c, input int n);
      case (c)
         8'h78: return 3;
         8'h20: return n;
         8'h38: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] rbyte(input logic [7:0] c, input int i, input int n);
      return c ^ 8'(i * 13) ^ 8'(n);
   endfunction

   function automatic logic [7:0] abyte(input logic [7:0] c, input int i);
      return 8'(c * 3 + i * 5 + 1);
   endfunction

   task automatic xfer(input bit dir, input logic [7:0] din, output logic [7:0] dout,
                       output bit got_done, output bit got_go);
      int lat;
      @(negedge clk);
      sr_dir = dir; sr_in = din; pb_we = 1'b1; pb_wdata = 8'h08;
      @(negedge clk);
      pb_we = 1'b0;
      got_done = 0; got_go = 0; dout = 8'h00; lat = 0;
      for (int k = 0; k < 6 && !got_done; k++) begin
         @(negedge clk);
         lat++;
         if (sr_done) begin
            got_done = 1; dout = sr_out; got_go = cmd_go;
            chk(lat == 1, "R4 done latency", lat, 1);
            chk(pb_rdata == 8'h00, "R4 ack low", pb_rdata, 8'h00);
         end
      end
      pb_we = 1'b1; pb_wdata = 8'h10;
      @(negedge clk);
      pb_we = 1'b0;
      @(negedge clk);
      chk(pb_rdata == 8'h18, "R3 ack release", pb_rdata, 8'h18);
   endtask

   task automatic execute(input logic [7:0] c, input int n, output int s);
      s = esize(c, n);
      for (int i = 0; i < s; i++) begin
         @(negedge clk);
         rsp_we = 1'b1; rsp_wr_idx = 8'(i); rsp_wr_data = rbyte(c, i, n);
      end
      @(negedge clk);
      rsp_we = 1'b0; exec_done = 1'b1; exec_rsp_len = 8'(s);
      @(negedge clk);
      exec_done = 1'b0;
   endtask

   task automatic run_cmd(input logic [7:0] c, input int n);
      bit cv, rv, ex, gd, gg, last_go;
      int cl, rl, nargs, s, total;
      logic [7:0] d, e;
      exp_lens(c, cv, cl, rv, rl, ex);
      nargs = cv ? n : cl;
      xfer(1'b1, c, d, gd, gg);
      chk(gd, "R6 code accepted", gd, 1);
      last_go = gg;
      if (cv) begin
         xfer(1'b1, 8'(n), d, gd, gg);
         chk(gd, "R7 length byte accepted", gd, 1);
         last_go = gg;
      end
      for (int i = 0; i < nargs; i++) begin
         xfer(1'b1, abyte(c, i), d, gd, gg);
         chk(gd, "R6 arg accepted", gd, 1);
         last_go = gg;
      end
      chk(last_go == ex, ex ? "R9 dispatch" : "R12 no dispatch", last_go, ex);
      s = 0;
      if (ex) begin
         chk(cmd_code == c, "R9 cmd code", cmd_code, c);
         chk(cmd_arg_cnt == 8'(nargs), "R9 arg count", cmd_arg_cnt, nargs);
         for (int i = 0; i < nargs && i < 32; i++) begin
            arg_rd_idx = 8'(i);
            #0.5;
            chk(arg_rd_data == abyte(c, i), "R6 arg stored", arg_rd_data, abyte(c, i));
         end
         if (nargs > 32) begin
            arg_rd_idx = 8'd32;
            #0.5;
            chk(arg_rd_data == 8'h00, "R8 beyond depth", arg_rd_data, 0);
         end
         execute(c, nargs, s);
      end
      if (rv) begin
         xfer(1'b0, 8'h00, d, gd, gg);
         chk(gd && d == 8'(s), ex ? "R11 length byte" : "R12 empty length", d, s);
         total = s;
      end else begin
         total = rl;
      end
      for (int i = 0; i < total; i++) begin
         e = (ex && i < s && i < 32) ? rbyte(c, i, nargs) : 8'h00;
         xfer(1'b0, 8'h00, d, gd, gg);
         chk(gd && d == e, ex ? "R10 rsp byte" : "R12 zero fill", d, e);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      bit gd, gg;
      int s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pb_rdata == 8'h18, "R1 port B", pb_rdata, 8'h18);
      chk(!sr_done, "R1 sr_done", sr_done, 0);
      chk(!cmd_go, "R1 cmd_go", cmd_go, 0);
      chk(sr_out == 8'h00, "R1 sr_out", sr_out, 0);

      // R2 invalid state ignored
      pb_we = 1'b1; pb_wdata = 8'h00;
      @(negedge clk);
      pb_we = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(!sr_done && pb_rdata == 8'h00, "R2 invalid ignored", pb_rdata, 8'h00);
      end
      pb_we = 1'b1; pb_wdata = 8'h18;
      @(negedge clk);
      pb_we = 1'b0;
      repeat (3) @(negedge clk);
      chk(pb_rdata == 8'h18 && !sr_done, "R2 idle", pb_rdata, 8'h18);

      // R5 direction error while idle
      xfer(1'b0, 8'h38, d, gd, gg);
      chk(!gd, "R5 idle wrong dir skipped", gd, 0);
      run_cmd(8'h10, 0);

      // sweep every code (R6 R7 R10 R11 R12)
      for (int c = 0; c < 256; c++) begin
         run_cmd(8'(c), (c == 8'h20 || c == 8'h41) ? c % 7 : 0);
      end

      // variable argument counts across the buffer edge (R7 R8)
      for (int n = 0; n <= 34; n++) run_cmd(8'h20, n);
      for (int n = 0; n <= 34; n += 17) run_cmd(8'h41, n);

      // R5 direction error while responding
      xfer(1'b1, 8'h78, d, gd, gg);
      chk(gd && gg, "R9 dispatch 0x78", gg, 1);
      execute(8'h78, 0, s);
      xfer(1'b1, 8'h00, d, gd, gg);
      chk(!gd, "R5 rsp wrong dir skipped", gd, 0);
      xfer(1'b0, 8'h00, d, gd, gg);
      chk(gd && d == 8'd3, "R11 length after skip", d, 3);
      for (int i = 0; i < 3; i++) begin
         xfer(1'b0, 8'h00, d, gd, gg);
         chk(gd && d == rbyte(8'h78, i, 0), "R11 rsp byte", d, rbyte(8'h78, i, 0));
      end

      // R9 request while executor busy is deferred
      xfer(1'b1, 8'h38, d, gd, gg);
      chk(gd && gg, "R9 dispatch 0x38", gg, 1);
      @(negedge clk);
      sr_dir = 1'b0; pb_we = 1'b1; pb_wdata = 8'h08;
      @(negedge clk);
      pb_we = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(!sr_done && pb_rdata == 8'h08, "R9 held while busy", pb_rdata, 8'h08);
      end
      execute(8'h38, 0, s);
      gd = 0;
      for (int k = 0; k < 4 && !gd; k++) begin
         if (sr_done) begin gd = 1; d = sr_out; end
         else @(negedge clk);
      end
      chk(gd && d == rbyte(8'h38, 0, 0), "R9 deferred request served", d, rbyte(8'h38, 0, 0));
      pb_we = 1'b1; pb_wdata = 8'h10;
      @(negedge clk);
      pb_we = 1'b0;
      @(negedge clk);
      for (int i = 1; i < 4; i++) begin
         xfer(1'b0, 8'h00, d, gd, gg);
         chk(gd && d == ((i < 2) ? rbyte(8'h38, i, 0) : 8'h00), "R10 fixed rsp", d,
             (i < 2) ? rbyte(8'h38, i, 0) : 8'h00);
      end
      // R10 back to idle: the next code byte is accepted
      run_cmd(8'h40, 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule